// File: doc/BRIEF.md
# Rotating Register Window Controller

This block holds the register-window state of a wide-issue processor core. The state covers the window size, the no-fill and double flags, the base and size of the rotating area, the current rotation offset and the predicate size. Decoded control commands load these fields from a literal word or from a control word. Each field is stored already scaled, so an address translator downstream can use the outputs directly.

At the end of every bundle the rotation offset may advance. A two-bit advance field comes with the bundle. The branch outcome selects which of its two bits applies. An advance adds two to the rotation and wraps it at the stored rotating-area size. The advance comes after the bundle's own set-rotating-area load, so it acts on a value loaded in the same cycle.

All updates happen on the rising clock edge. A set-window command with no literal attached is refused and flagged on an error output. Fetch, the exceptions for illegal settings and the branch decision are handled elsewhere.

Top module: `rwin_ctrl`

## Requirements
- R1: A synchronous reset clears every output to zero: window size, flags, rotating base, size and offset, predicate size and error.
- R2: A set-window command with a literal present sets the window size to twice literal bits 11:5 and the no-fill flag to literal bit 4.
- R3: On that command the double flag takes literal bit 3 only when the core version input is 3 or higher. Below version 3 the double flag keeps its value.
- R4: A set-window command without a literal raises the error output for the single following cycle and leaves all window fields unchanged. The error output is low in every other cycle.
- R5: A set-rotating-area command sets the rotation offset to twice control bits 17:12, the rotating size to twice control bits 11:6 plus two, and the rotating base to twice control bits 5:0.
- R6: A set-predicate-base command sets the predicate size to control bits 22:18.
- R7: At a bundle end with no branch taken, the rotation advances only if bit 1 of the advance field is set. With a branch taken, it advances only if bit 0 is set. Outside a bundle end the rotation never moves.
- R8: An advance adds 2 to the rotation. When the sum is not below the rotating size, the size is subtracted, so an offset inside the area stays inside it.
- R9: When a set-rotating-area command and an advancing bundle end fall in the same cycle, the advance is applied to the newly loaded offset and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_ver | input | CORE_VER_W | Core version number |
| set_win | input | 1 | Set-window command strobe |
| lit_valid | input | 1 | A literal word accompanies the bundle |
| lit_word | input | WORD_W | Literal word |
| set_rot | input | 1 | Set-rotating-area command strobe |
| set_pred | input | 1 | Set-predicate-base command strobe |
| ctrl_word | input | WORD_W | Control word |
| bundle_end | input | 1 | Last cycle of the bundle |
| br_taken | input | 1 | A branch is taken in this bundle |
| adv_field | input | 2 | Rotate-advance bits: bit 1 for no branch, bit 0 for branch |
| win_size | output | 8 | Window size, scaled by two |
| no_fill | output | 1 | No-fill flag |
| dbl | output | 1 | Double flag |
| rot_base | output | 7 | Rotating-area base, scaled by two |
| rot_size | output | 8 | Rotating-area size, twice field plus two |
| rot_cur | output | 7 | Current rotation offset, scaled by two |
| pred_size | output | 5 | Predicate size |
| err | output | 1 | Set-window refused: no literal present |

## Verification
Every result is registered once. A command or bundle end presented in one cycle shows on the outputs after the next rising edge, and the error pulse lasts exactly that one cycle. The bench drives inputs on the falling edge and samples outputs on the following falling edge, which is half a period after the edge that captured them. It then clears the strobes and checks that the error has dropped and the held fields have not moved. The rotation table runs the load-and-advance sequence cycle by cycle, including wraps at sizes 2, 4 and 6 and a load that coincides with an advance.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    // field geometry of the command words
    localparam int WSZ_FW   = 7;
    localparam int ROT_FW   = 6;
    localparam int PSZ_FW   = 5;

    localparam int WSZ_LSB  = 5;
    localparam int NFX_BIT  = 4;
    localparam int DBL_BIT  = 3;
    localparam int RBS_LSB  = 0;
    localparam int RSZ_LSB  = 6;
    localparam int RCUR_LSB = 12;
    localparam int PSZ_LSB  = 18;

    // stored (scaled) widths
    localparam int WSZ_W = WSZ_FW + 1;
    localparam int ROT_W = ROT_FW + 1;
    localparam int RSZ_W = ROT_FW + 2;

    typedef struct packed {
        logic [WSZ_W-1:0]  win_size;
        logic              no_fill;
        logic              dbl;
        logic [ROT_W-1:0]  rot_base;
        logic [RSZ_W-1:0]  rot_size;
        logic [ROT_W-1:0]  rot_cur;
        logic [PSZ_FW-1:0] pred_size;
        logic              err;
    } rwin_state_t;

endpackage

// File: rtl/rwin_decode.sv
module rwin_decode
    import rwin_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] lit_word,
    input  logic [WORD_W-1:0] ctrl_word,
    output logic [WSZ_W-1:0]  win_size,
    output logic              no_fill,
    output logic              dbl,
    output logic [ROT_W-1:0]  rot_base,
    output logic [RSZ_W-1:0]  rot_size,
    output logic [ROT_W-1:0]  rot_cur,
    output logic [PSZ_FW-1:0] pred_size
);

    logic [WSZ_FW-1:0] wsz_f;
    logic [ROT_FW-1:0] rbs_f;
    logic [ROT_FW-1:0] rsz_f;
    logic [ROT_FW-1:0] rcur_f;

    always_comb begin
        wsz_f     = lit_word[WSZ_LSB +: WSZ_FW];
        rbs_f     = ctrl_word[RBS_LSB +: ROT_FW];
        rsz_f     = ctrl_word[RSZ_LSB +: ROT_FW];
        rcur_f    = ctrl_word[RCUR_LSB +: ROT_FW];

        win_size  = {wsz_f, 1'b0};
        no_fill   = lit_word[NFX_BIT];
        dbl       = lit_word[DBL_BIT];
        rot_base  = {rbs_f, 1'b0};
        rot_cur   = {rcur_f, 1'b0};
        rot_size  = {1'b0, rsz_f, 1'b0} + RSZ_W'(2);
        pred_size = ctrl_word[PSZ_LSB +: PSZ_FW];
    end

    // bits of the words that carry no field of this block
    logic unused_bits;
    assign unused_bits = ^{lit_word[WORD_W-1:WSZ_LSB+WSZ_FW], lit_word[DBL_BIT-1:0],
                           ctrl_word[WORD_W-1:PSZ_LSB+PSZ_FW]};

endmodule

// File: rtl/rwin_advance.sv
module rwin_advance
    import rwin_pkg::*;
(
    input  logic [ROT_W-1:0] rot_in,
    input  logic [RSZ_W-1:0] size,
    input  logic             bundle_end,
    input  logic             br_taken,
    input  logic [1:0]       adv_field,
    output logic             step,
    output logic [ROT_W-1:0] rot_out
);

    logic [RSZ_W-1:0] sum;
    logic [RSZ_W-1:0] wrapped;

    always_comb begin
        // bit 1 governs the fall-through case, bit 0 the taken case
        step    = bundle_end && (br_taken ? adv_field[0] : adv_field[1]);
        sum     = {1'b0, rot_in} + RSZ_W'(2);
        wrapped = (sum >= size) ? (sum - size) : sum;
        rot_out = step ? wrapped[ROT_W-1:0] : rot_in;
    end

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int CORE_VER_W  = 8,
    parameter int DBL_MIN_VER = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CORE_VER_W-1:0] core_ver,
    input  logic                  set_win,
    input  logic                  lit_valid,
    input  logic [WORD_W-1:0]     lit_word,
    input  logic                  set_rot,
    input  logic                  set_pred,
    input  logic [WORD_W-1:0]     ctrl_word,
    input  logic                  bundle_end,
    input  logic                  br_taken,
    input  logic [1:0]            adv_field,
    output logic [7:0]            win_size,
    output logic                  no_fill,
    output logic                  dbl,
    output logic [6:0]            rot_base,
    output logic [7:0]            rot_size,
    output logic [6:0]            rot_cur,
    output logic [4:0]            pred_size,
    output logic                  err
);

    localparam logic [CORE_VER_W-1:0] DBL_VER = CORE_VER_W'(DBL_MIN_VER);

    rwin_state_t st_q, st_d, ld;

    logic [WSZ_W-1:0]  dec_wsz;
    logic              dec_nfx;
    logic              dec_dbl;
    logic [ROT_W-1:0]  dec_rbs;
    logic [RSZ_W-1:0]  dec_rsz;
    logic [ROT_W-1:0]  dec_rcur;
    logic [PSZ_FW-1:0] dec_psz;
    logic              adv_step;
    logic [ROT_W-1:0]  adv_rot;

    rwin_decode #(.WORD_W(WORD_W)) u_dec (
        .lit_word  (lit_word),
        .ctrl_word (ctrl_word),
        .win_size  (dec_wsz),
        .no_fill   (dec_nfx),
        .dbl       (dec_dbl),
        .rot_base  (dec_rbs),
        .rot_size  (dec_rsz),
        .rot_cur   (dec_rcur),
        .pred_size (dec_psz)
    );

    // load stage: commands of the bundle
    always_comb begin
        ld     = st_q;
        ld.err = 1'b0;
        if (set_win) begin
            if (lit_valid) begin
                ld.win_size = dec_wsz;
                ld.no_fill  = dec_nfx;
                if (core_ver >= DBL_VER) begin
                    ld.dbl = dec_dbl;
                end
            end else begin
                ld.err = 1'b1;
            end
        end
        if (set_rot) begin
            ld.rot_cur  = dec_rcur;
            ld.rot_size = dec_rsz;
            ld.rot_base = dec_rbs;
        end
        if (set_pred) begin
            ld.pred_size = dec_psz;
        end
    end

    // rotation advance acts on the freshly loaded values
    rwin_advance u_adv (
        .rot_in     (ld.rot_cur),
        .size       (ld.rot_size),
        .bundle_end (bundle_end),
        .br_taken   (br_taken),
        .adv_field  (adv_field),
        .step       (adv_step),
        .rot_out    (adv_rot)
    );

    always_comb begin
        st_d         = ld;
        st_d.rot_cur = adv_rot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_size  = st_q.win_size;
    assign no_fill   = st_q.no_fill;
    assign dbl       = st_q.dbl;
    assign rot_base  = st_q.rot_base;
    assign rot_size  = st_q.rot_size;
    assign rot_cur   = st_q.rot_cur;
    assign pred_size = st_q.pred_size;
    assign err       = st_q.err;

    // ---------------- assertions ----------------
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (win_size == 8'd0 && rot_cur == 7'd0 && rot_size == 8'd0 &&
                 rot_base == 7'd0 && pred_size == 5'd0 && !err && !dbl && !no_fill));

    a_r2_window_load: assert property (@(posedge clk) disable iff (rst)
        (set_win && lit_valid) |=> (win_size == {$past(lit_word[11:5]), 1'b0}
                                    && no_fill == $past(lit_word[4])));

    a_r3_dbl_gated: assert property (@(posedge clk) disable iff (rst)
        (set_win && core_ver < DBL_VER) |=> $stable(dbl));

    a_r4_err_pulse: assert property (@(posedge clk) disable iff (rst)
        (set_win && !lit_valid) |=> (err && $stable(win_size) && $stable(no_fill)));

    a_r4_err_cause: assert property (@(posedge clk) disable iff (rst)
        !(set_win && !lit_valid) |=> !err);

    a_r5_size_load: assert property (@(posedge clk) disable iff (rst)
        set_rot |=> (rot_size == {1'b0, $past(ctrl_word[11:6]), 1'b0} + 8'd2
                     && rot_base == {$past(ctrl_word[5:0]), 1'b0}));

    a_r6_pred_load: assert property (@(posedge clk) disable iff (rst)
        set_pred |=> pred_size == $past(ctrl_word[22:18]));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_rot && !adv_step) |=> $stable(rot_cur));

    a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
        (!set_rot && bundle_end && rot_cur < rot_size) |=> rot_cur < rot_size);

    a_r8_even: assert property (@(posedge clk) disable iff (rst)
        rot_cur[0] == 1'b0);

endmodule

// File: tb/sim_rwin_ctrl.sv
module sim_rwin_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  core_ver;
    logic        set_win, lit_valid, set_rot, set_pred;
    logic [31:0] lit_word, ctrl_word;
    logic        bundle_end, br_taken;
    logic [1:0]  adv_field;
    logic [7:0]  win_size, rot_size;
    logic        no_fill, dbl, err;
    logic [6:0]  rot_base, rot_cur;
    logic [4:0]  pred_size;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rwin_ctrl u0 (
        .clk(clk), .rst(rst), .core_ver(core_ver), .set_win(set_win),
        .lit_valid(lit_valid), .lit_word(lit_word), .set_rot(set_rot),
        .set_pred(set_pred), .ctrl_word(ctrl_word), .bundle_end(bundle_end),
        .br_taken(br_taken), .adv_field(adv_field), .win_size(win_size),
        .no_fill(no_fill), .dbl(dbl), .rot_base(rot_base), .rot_size(rot_size),
        .rot_cur(rot_cur), .pred_size(pred_size), .err(err)
    );

    typedef struct packed {
        logic       ld;
        logic [5:0] cur;
        logic [5:0] sz;
        logic       be;
        logic       br;
        logic [1:0] adv;
        logic [6:0] exp_rot;
        logic [7:0] exp_sz;
    } vec_t;

    // rotation sequence: loads, advances and wraps (R5, R7, R8, R9)
    localparam vec_t VECS [0:11] = '{
        '{1'b1, 6'd1, 6'd2, 1'b0, 1'b0, 2'b00, 7'd2, 8'd6},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b0, 2'b10, 7'd4, 8'd6},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b0, 2'b01, 7'd4, 8'd6},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b1, 2'b01, 7'd0, 8'd6},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b1, 2'b10, 7'd0, 8'd6},
        '{1'b0, 6'd0, 6'd0, 1'b0, 1'b0, 2'b11, 7'd0, 8'd6},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b0, 2'b11, 7'd2, 8'd6},
        '{1'b1, 6'd2, 6'd1, 1'b1, 1'b0, 2'b10, 7'd2, 8'd4},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b1, 2'b11, 7'd0, 8'd4},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b1, 2'b11, 7'd2, 8'd4},
        '{1'b1, 6'd0, 6'd0, 1'b0, 1'b0, 2'b00, 7'd0, 8'd2},
        '{1'b0, 6'd0, 6'd0, 1'b1, 1'b0, 2'b10, 7'd0, 8'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        set_win = 0; lit_valid = 0; set_rot = 0; set_pred = 0;
        bundle_end = 0; br_taken = 0; adv_field = 2'b00;
        lit_word = '0; ctrl_word = '0;
    endtask

    // inputs driven at a falling edge, results read at the next falling edge
    task automatic cycle();
        @(negedge clk);
    endtask

    initial begin
        rst = 1; core_ver = 8'd2;
        idle();
        cycle(); cycle();
        rst = 0;
        check("R1 rot_cur", {25'd0, rot_cur}, 0);
        check("R1 win_size", {24'd0, win_size}, 0);
        check("R1 err", {31'd0, err}, 0);

        // R2 / R3 : window literal, version below gate
        set_win = 1; lit_valid = 1; lit_word = 32'h0000_0FF8; core_ver = 8'd2;
        cycle(); idle();
        check("R2 win_size", {24'd0, win_size}, 254);
        check("R2 no_fill", {31'd0, no_fill}, 1);
        check("R3 dbl held at v2", {31'd0, dbl}, 0);

        // R3 : version 3 takes bit 3
        set_win = 1; lit_valid = 1; lit_word = 32'h0000_0048; core_ver = 8'd3;
        cycle(); idle();
        check("R3 dbl set v3", {31'd0, dbl}, 1);
        check("R2 win_size 2", {24'd0, win_size}, 4);
        check("R2 no_fill 0", {31'd0, no_fill}, 0);

        // R3 : version 2 with bit 3 clear leaves dbl set
        set_win = 1; lit_valid = 1; lit_word = 32'h0000_0020; core_ver = 8'd2;
        cycle(); idle();
        check("R3 dbl kept", {31'd0, dbl}, 1);

        // R4 : no literal
        set_win = 1; lit_valid = 0; lit_word = 32'h0000_0FF0;
        cycle(); idle();
        check("R4 err", {31'd0, err}, 1);
        check("R4 win_size unchanged", {24'd0, win_size}, 2);
        check("R4 no_fill unchanged", {31'd0, no_fill}, 0);
        cycle();
        check("R4 err drops", {31'd0, err}, 0);

        // R5 base and R6 predicate
        set_rot = 1; set_pred = 1; ctrl_word = 32'h007C_003F;
        cycle(); idle();
        check("R5 rot_base", {25'd0, rot_base}, 126);
        check("R5 rot_size", {24'd0, rot_size}, 2);
        check("R6 pred_size", {27'd0, pred_size}, 31);

        // rotation table
        foreach (VECS[i]) begin
            set_rot    = VECS[i].ld;
            ctrl_word  = {14'd0, VECS[i].cur, VECS[i].sz, 6'd0};
            bundle_end = VECS[i].be;
            br_taken   = VECS[i].br;
            adv_field  = VECS[i].adv;
            cycle(); idle();
            check($sformatf("R7 R8 R9 rot_cur vec %0d", i), {25'd0, rot_cur}, {25'd0, VECS[i].exp_rot});
            check($sformatf("R5 rot_size vec %0d", i), {24'd0, rot_size}, {24'd0, VECS[i].exp_sz});
        end

        // R7 : no bundle end, advance bits set
        set_rot = 1; ctrl_word = {14'd0, 6'd3, 6'd5, 6'd0};
        cycle(); idle();
        check("R5 rot_cur load", {25'd0, rot_cur}, 6);
        adv_field = 2'b11; br_taken = 1;
        cycle(); idle();
        check("R7 no bundle end", {25'd0, rot_cur}, 6);
        bundle_end = 1; adv_field = 2'b10;
        cycle(); idle();
        check("R8 step to 8", {25'd0, rot_cur}, 8);

        // R1 : reset again
        rst = 1;
        cycle();
        rst = 0;
        check("R1 rot_size", {24'd0, rot_size}, 0);
        check("R1 dbl", {31'd0, dbl}, 0);
        check("R1 pred_size", {27'd0, pred_size}, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule